// File: doc/BRIEF.md
# Timer Channel Output Pin Controller

This block drives the output pin of a single timer channel. It takes two single-cycle event strobes, one from a master channel and one from its slave channel. A one-bit output latch drives the pin directly. Three control bits decide how the strobes act on the latch:

- an enable bit decides whether the latch follows the timer events or software writes;
- a mode bit selects toggle behaviour or set/reset combination behaviour;
- a level bit selects forward or reverse polarity in combination mode.

Software reaches the control bits and the output latch through a small write-strobe/address/data register port. The port has a combinational read path. The latch can be read back at any time, whatever the control state.

The timer counters that produce the strobes are outside this block. When both strobes arrive in one cycle, the slave strobe takes precedence, so a zero-duty PWM gives a steady inactive level. Because the enable bit gives the latch to exactly one owner, a timer cannot be disturbed by a stray software write, and a software-driven level cannot be upset by a running timer.

Top module: `tmr_out_ctrl`

## Requirements
- R1: After the asynchronous reset (`rst_ni` low), the pin and the output latch are 0, and the control register reads back as 0.
- R2: A write to address 0 loads the control bits from `wdata_i`: bit 0 is enable, bit 1 is mode, bit 2 is level. Reading address 0 returns those three bits in the same positions, with all other bits 0. The new values act from the next clock edge.
- R3: With enable 1 and mode 0 (toggle), each slave strobe inverts the latch. Master strobes have no effect, and the level bit has no effect.
- R4: With enable 1, mode 1 and level 0 (forward), a master strobe sets the latch to 1 and a slave strobe clears it to 0.
- R5: With enable 1, mode 1 and level 1 (reverse), a master strobe clears the latch to 0 and a slave strobe sets it to 1.
- R6: In combination mode, when master and slave strobes come in the same cycle, the slave strobe wins. The latch becomes 0 in forward and 1 in reverse.
- R7: With enable 1, a software write to address 1 leaves the latch unchanged. Only the two strobes can change the pin.
- R8: With enable 0, neither strobe changes the latch. A write to address 1 loads `wdata_i` bit 0 into the latch.
- R9: Reading address 1 returns the latch in bit 0 (other bits 0) whatever the enable bit, and `tout_o` always equals the latch.
- R10: A strobe sampled at a clock edge changes `tout_o` right after that edge and not before it. There is no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address (0 control, 1 output latch) |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| mst_evt_i | input | 1 | Master channel event strobe, one cycle |
| slv_evt_i | input | 1 | Slave channel event strobe, one cycle |
| tout_o | output | 1 | Channel output pin |

## Verification
Two functions can fall in the same cycle: the master strobe and the slave strobe. Coinciding strobes are the zero-duty case. The bench raises both strobes together for one cycle in forward, reverse and toggle settings, each from a chosen starting latch level, so that the winning strobe is visible in the result. The latch is judged one edge later against the level the slave strobe alone would give: 0 in forward, 1 in reverse, and an inversion in toggle. A software write to the output latch that lands while timer events own the latch is also provoked, and it is judged by reading the latch back.

// File: rtl/tcop_pkg.sv
package tcop_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_OUT  = 1;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_MODE = 1;
  localparam int unsigned BIT_LVL  = 2;

  typedef struct packed {
    logic lvl;
    logic mode;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } act_e;
endpackage

// File: rtl/tcop_ctrl_regs.sv
module tcop_ctrl_regs #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 q_i,
  output tcop_pkg::ctrl_t      ctrl_o,
  output logic                 sw_wr_o,
  output logic                 sw_bit_o,
  output logic [DATA_W-1:0]    rdata_o
);
  import tcop_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(ADDR_OUT);

  ctrl_t ctrl_q;
  logic  ctrl_we;

  assign ctrl_we  = wr_en_i && (addr_i == A_CTRL);
  assign sw_wr_o  = wr_en_i && (addr_i == A_OUT);
  assign sw_bit_o = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.en   <= wdata_i[BIT_EN];
      ctrl_q.mode <= wdata_i[BIT_MODE];
      ctrl_q.lvl  <= wdata_i[BIT_LVL];
    end
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[BIT_EN]   = ctrl_q.en;
      rdata_o[BIT_MODE] = ctrl_q.mode;
      rdata_o[BIT_LVL]  = ctrl_q.lvl;
    end else if (addr_i == A_OUT) begin
      rdata_o[0] = q_i;
    end
  end
endmodule

// File: rtl/tcop_evt_decode.sv
module tcop_evt_decode (
  input  tcop_pkg::ctrl_t ctrl_i,
  input  logic            mst_evt_i,
  input  logic            slv_evt_i,
  output tcop_pkg::act_e  act_o
);
  import tcop_pkg::*;

  always_comb begin
    act_o = ACT_HOLD;
    if (ctrl_i.en) begin
      if (!ctrl_i.mode) begin
        if (slv_evt_i) act_o = ACT_TOG;
      end else if (slv_evt_i) begin
        // slave has priority: masks a coincident master strobe
        act_o = ctrl_i.lvl ? ACT_SET : ACT_CLR;
      end else if (mst_evt_i) begin
        act_o = ctrl_i.lvl ? ACT_CLR : ACT_SET;
      end
    end
  end
endmodule

// File: rtl/tcop_out_latch.sv
module tcop_out_latch (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  tcop_pkg::act_e act_i,
  input  logic           sw_wr_i,
  input  logic           sw_bit_i,
  output logic           q_o
);
  import tcop_pkg::*;

  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) begin
      unique case (act_i)
        ACT_SET:  q_d = 1'b1;
        ACT_CLR:  q_d = 1'b0;
        ACT_TOG:  q_d = ~q_q;
        default:  q_d = q_q;
      endcase
    end else if (sw_wr_i) begin
      q_d = sw_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              mst_evt_i,
  input  logic              slv_evt_i,
  output logic              tout_o
);
  import tcop_pkg::*;

  ctrl_t ctrl;
  act_e  act;
  logic  sw_wr, sw_bit, q;
  logic  en_q, mode_q, lvl_q;

  tcop_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .q_i      (q),
    .ctrl_o   (ctrl),
    .sw_wr_o  (sw_wr),
    .sw_bit_o (sw_bit),
    .rdata_o  (rdata_o)
  );

  tcop_evt_decode u_dec (
    .ctrl_i    (ctrl),
    .mst_evt_i (mst_evt_i),
    .slv_evt_i (slv_evt_i),
    .act_o     (act)
  );

  tcop_out_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl.en),
    .act_i    (act),
    .sw_wr_i  (sw_wr),
    .sw_bit_i (sw_bit),
    .q_o      (q)
  );

  assign en_q   = ctrl.en;
  assign mode_q = ctrl.mode;
  assign lvl_q  = ctrl.lvl;
  assign tout_o = q;
endmodule

// File: rtl/tmr_out_ctrl_chk.sv
module tmr_out_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en,
  input logic mode,
  input logic lvl,
  input logic mst,
  input logic slv,
  input logic sw_wr,
  input logic sw_bit,
  input logic q
);
  AST_TOGGLE_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !mode && slv |=> q != $past(q)); // R3
  AST_TOGGLE_MST_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !mode && mst && !slv |=> $stable(q)); // R3
  AST_COMB_SLV_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && mode && slv |=> q == $past(lvl)); // R6
  AST_COMB_MST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && mode && mst && !slv |=> q == !$past(lvl)); // R4
  AST_SW_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !mst && !slv |=> $stable(q)); // R7
  AST_EVT_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !sw_wr |=> $stable(q)); // R8
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && sw_wr |=> q == $past(sw_bit)); // R8
endmodule

bind tmr_out_ctrl tmr_out_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en     (en_q),
  .mode   (mode_q),
  .lvl    (lvl_q),
  .mst    (mst_evt_i),
  .slv    (slv_evt_i),
  .sw_wr  (wr_en_i && (addr_i == 1)),
  .sw_bit (wdata_i[0]),
  .q      (tout_o)
);

// File: tb/tmr_out_ctrl_tb.sv
module tmr_out_ctrl_tb;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int NV = 16;

  // {en, mode, lvl, init, mst, slv, exp}
  localparam logic [6:0] VEC [NV] = '{
    7'b100_0_01_1, 7'b100_1_01_0, 7'b101_0_10_0, 7'b101_0_01_1,
    7'b100_1_11_0, 7'b110_0_10_1, 7'b110_1_01_0, 7'b110_1_10_1,
    7'b110_1_11_0, 7'b111_1_10_0, 7'b111_0_01_1, 7'b111_0_11_1,
    7'b111_0_10_0, 7'b010_0_10_0, 7'b000_1_01_1, 7'b011_1_11_1
  };

  logic clk = 0, rst_n = 0, we = 0, mst = 0, slv = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic tout;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tmr_out_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mst_evt_i(mst), .slv_evt_i(slv), .tout_o(tout)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk); we = 1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic pulse(input logic m, input logic s);
    @(negedge clk); mst = m; slv = s;
    @(negedge clk); mst = 0; slv = 0;
  endtask

  task automatic rd(input int a);
    addr = ADDR_W'(a); #1;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    #23; rst_n = 1;
    // R1 reset state
    @(negedge clk); rd(0);
    chk("R1 ctrl", rdata, 8'h00);
    chk("R1 pin", {7'b0, tout}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      v = VEC[i];
      wr(0, 8'h00);
      wr(1, {7'b0, v[3]});
      wr(0, {5'b0, v[4], v[5], v[6]});
      pulse(v[2], v[1]);
      if (!v[6])              tag = "R8";
      else if (!v[5])         tag = "R3";
      else if (v[2] && v[1])  tag = "R6";
      else if (!v[4])         tag = "R4";
      else                    tag = "R5";
      chk(tag, {7'b0, tout}, {7'b0, v[0]});
      rd(1);
      chk("R9 readback", rdata, {7'b0, v[0]});
    end

    // R2 control field positions and readback
    wr(0, 8'hFF); rd(0);
    chk("R2 ctrl bits", rdata, 8'h07);
    wr(0, 8'h05); rd(0);
    chk("R2 ctrl bits", rdata, 8'h05);

    // R7 software write ignored when enabled (reverse mode, latch 0)
    wr(0, 8'h00); wr(1, 8'h00); wr(0, 8'h07);
    wr(1, 8'h01); rd(1);
    chk("R7 sw write ignored", rdata, 8'h00);
    chk("R9 pin equals latch", {7'b0, tout}, 8'h00);

    // R10 timing: forward mode, latch 0, master strobe
    wr(0, 8'h03);
    @(negedge clk); mst = 1; #1;
    chk("R10 no change before edge", {7'b0, tout}, 8'h00);
    @(posedge clk); #1; mst = 0;
    chk("R10 change after edge", {7'b0, tout}, 8'h01);

    // R8 sw write takes effect when disabled, R1 reset clears it
    wr(0, 8'h00); wr(1, 8'h00); rd(1);
    chk("R8 sw write", rdata, 8'h00);
    wr(1, 8'h01);
    chk("R8 sw write", {7'b0, tout}, 8'h01);
    wr(0, 8'h07);
    @(negedge clk); rst_n = 0; #1; rd(0);
    chk("R1 async reset ctrl", rdata, 8'h00);
    chk("R1 async reset pin", {7'b0, tout}, 8'h00);
    rst_n = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule